// File: doc/BRIEF.md
# DRQ-Gated CPU Wait Trap for a Floppy Data Path

This block is glue logic that lets a CPU act as the DMA engine of a floppy disk controller. Software arms the trap and starts a timeout timer through a bit-addressed control port. It then runs a tight loop. Each pass of the loop touches a wait address, which pulls the CPU READY line low. It then reads or writes a data address, which asserts an active-low DMA acknowledge toward the controller. READY is held low until the controller raises its DMA request. The timeout timer stops the loop from hanging when the disk never produces data.

A small controller-side model stands for the controller's one-byte data buffer. In the read direction, bytes arrive from the data separator over a valid/ready stream. A byte is accepted only while `sep_ready` is high, and `sep_ready` is low while the buffer is occupied or while the acknowledge is active. A held byte raises DRQ. In the write direction, DRQ signals an empty buffer. A byte written by the CPU is offered on the formatter stream. It stays valid and unchanged until `fmt_ready` accepts it, so a stalled formatter back-pressures the CPU through DRQ.

The sector loop runs 256 passes. Afterwards, software reads `tmo_active`: high means every byte arrived, low means the timer broke a stall.

Top module: `dma_ready_trap`

## Requirements
- R1: After reset, cpu_ready=1, dack_n=1, drq=0, tmo_active=0, sep_ready=1 and fmt_valid=0. The control bits are all 0, which means disarmed and read direction.
- R2: While the arm bit (control bit 14) is 0, cpu_ready stays 1 whatever the bus does.
- R3: When armed and with the timer running, a read or write strobe at the wait address 0xFE00 while drq=0 drives cpu_ready low in that same cycle. cpu_ready stays low until drq is 1, and goes high in the first cycle drq is 1.
- R4: cpu_ready is 1 whenever the timer is idle. A stall is released in the cycle the timer expires, including a stall raised in the timer's last running cycle.
- R5: Writing 0 to the arm bit releases an active stall in the cycle after the control write.
- R6: A read strobe at 0xFE02 or a write strobe at 0xFE04 drives dack_n low from the first clock edge that sees the strobe. dack_n returns high at the first edge after the strobe ends. During a read acknowledge, bus_rdata carries the buffered byte.
- R7: In the read direction, the clock edge that sees dack_n low empties the buffer, so drq=0 after that edge.
- R8: While control bit 4 is 1, dack_n is low. In the read direction this discards a stale byte without any bus strobe: the byte is dropped and drq goes low.
- R9: Control bit 0 = 1 selects the write direction, in which drq=1 means the buffer is empty. A write acknowledge loads bus_wdata into the buffer, and drq falls at the edge after the acknowledge. The byte is then held on fmt_valid/fmt_data until fmt_ready is seen, and drq returns to 1 after that handshake.
- R10: sep_ready is 1 only in the read direction, with the buffer empty and dack_n high. A byte is taken only on an edge where sep_valid and sep_ready are both 1, and drq rises after that edge.
- R11: Writing 1 to control bit 6 loads the timer. tmo_active is then 1 for exactly TMO_CYCLES cycles after that edge.
- R12: Strobes at any other address, a write at 0xFE02 and a read at 0xFE04 cause neither an acknowledge nor a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | CPU address |
| bus_rd | input | 1 | CPU read strobe |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Buffered byte during a read acknowledge, else 0 |
| cpu_ready | output | 1 | CPU READY, low while stalled |
| ctl_we | input | 1 | Control bit write strobe |
| ctl_idx | input | 4 | Control bit number |
| ctl_val | input | 1 | Control bit value |
| tmo_active | output | 1 | Timeout timer running |
| dack_n | output | 1 | Active-low DMA acknowledge |
| drq | output | 1 | DMA request from the controller model |
| sep_valid | input | 1 | Separator byte valid |
| sep_data | input | 8 | Separator byte |
| sep_ready | output | 1 | Buffer can take a separator byte |
| fmt_valid | output | 1 | Byte offered to the formatter |
| fmt_data | output | 8 | Byte to the formatter |
| fmt_ready | input | 1 | Formatter accepts the byte |

## Verification
Two pairs of events can land on the same clock edge, and each pair gets its own test.

The first pair is a stall request and timer expiry. A wait access is started in the timer's final running cycle. READY must fall in that cycle and rise at the very next edge, with tmo_active falling at that same edge.

The second pair is an acknowledge emptying the buffer and a separator byte arriving. A new separator byte is presented while dack_n is still low. The test requires sep_ready to stay low, the buffer to empty at that edge, and the new byte to be taken only at the following edge and returned intact by the next read.

// File: rtl/dma_trap_pkg.sv
package dma_trap_pkg;
  typedef enum logic {
    XFER_READ  = 1'b0,
    XFER_WRITE = 1'b1
  } xfer_dir_e;

  typedef struct packed {
    logic rd_hit;
    logic wr_hit;
    logic wait_hit;
  } bus_hits_t;
endpackage

// File: rtl/trap_ctl_port.sv
module trap_ctl_port
  import dma_trap_pkg::*;
#(
  parameter int CTL_W      = 16,
  parameter int ARM_BIT    = 14,
  parameter int ACK_BIT    = 4,
  parameter int DIR_BIT    = 0,
  parameter int TMO_BIT    = 6,
  parameter int TMO_CYCLES = 3000,
  localparam int IDX_W     = $clog2(CTL_W),
  localparam int TW        = $clog2(TMO_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [IDX_W-1:0] ctl_idx,
  input  logic             ctl_val,
  output logic             arm,
  output logic             ack,
  output xfer_dir_e        dir,
  output logic             dir_chg,
  output logic             tmo_active
);
  localparam int NB = 3;
  localparam int BIT_POS [NB] = '{ARM_BIT, ACK_BIT, DIR_BIT};

  logic [NB-1:0] bits_q;
  logic [TW-1:0] tmo_cnt_q;
  logic          trigger;

  // one flop per stored control bit
  for (genvar g = 0; g < NB; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bits_q[g] <= 1'b0;
      end else if (ctl_we && (ctl_idx == IDX_W'(BIT_POS[g]))) begin
        bits_q[g] <= ctl_val;
      end
    end
  end

  assign arm     = bits_q[0];
  assign ack     = bits_q[1];
  assign dir     = xfer_dir_e'(bits_q[2]);
  assign dir_chg = ctl_we && (ctl_idx == IDX_W'(DIR_BIT)) && (ctl_val != bits_q[2]);
  assign trigger = ctl_we && (ctl_idx == IDX_W'(TMO_BIT)) && ctl_val;

  // retriggerable timeout timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_cnt_q <= '0;
    end else if (trigger) begin
      tmo_cnt_q <= TW'(TMO_CYCLES);
    end else if (tmo_cnt_q != '0) begin
      tmo_cnt_q <= tmo_cnt_q - 1'b1;
    end
  end

  assign tmo_active = (tmo_cnt_q != '0);
endmodule

// File: rtl/trap_addr_decode.sv
module trap_addr_decode
  import dma_trap_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] WAIT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] RD_ADDR   = 16'hFE02,
  parameter logic [ADDR_W-1:0] WR_ADDR   = 16'hFE04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              ack,
  output logic              wait_hit,
  output logic              dack,
  output logic              dack_wr,
  output logic [DATA_W-1:0] wdata_q
);
  bus_hits_t hits;

  always_comb begin
    hits.rd_hit   = bus_rd && (bus_addr == RD_ADDR);
    hits.wr_hit   = bus_wr && (bus_addr == WR_ADDR);
    hits.wait_hit = (bus_rd || bus_wr) && (bus_addr == WAIT_ADDR);
  end

  assign wait_hit = hits.wait_hit;

  // acknowledge follows the strobe by one edge and drops one edge after it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dack    <= 1'b0;
      dack_wr <= 1'b0;
      wdata_q <= '0;
    end else begin
      dack    <= hits.rd_hit || hits.wr_hit || ack;
      dack_wr <= hits.wr_hit;
      if (hits.wr_hit) begin
        wdata_q <= bus_wdata;
      end
    end
  end
endmodule

// File: rtl/trap_ready_gate.sv
module trap_ready_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tmo_active,
  input  logic drq,
  input  logic wait_hit,
  output logic cpu_ready
);
  logic stall_q;
  logic stall_now;

  // a stall lives while armed, timer running and no request; a wait hit opens it
  assign stall_now = arm && tmo_active && !drq && (stall_q || wait_hit);
  assign cpu_ready = !stall_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
    end else begin
      stall_q <= stall_now;
    end
  end
endmodule

// File: rtl/trap_drq_model.sv
module trap_drq_model
  import dma_trap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xfer_dir_e         dir,
  input  logic              dir_chg,
  input  logic              dack,
  input  logic              dack_wr,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic              sep_valid,
  input  logic [DATA_W-1:0] sep_data,
  output logic              sep_ready,
  output logic              fmt_valid,
  output logic [DATA_W-1:0] fmt_data,
  input  logic              fmt_ready,
  output logic              drq,
  output logic [DATA_W-1:0] rd_data
);
  logic              full_q;
  logic [DATA_W-1:0] buf_q;
  logic              is_wr;

  assign is_wr     = (dir == XFER_WRITE);
  assign sep_ready = !is_wr && !full_q && !dack;
  assign fmt_valid = is_wr && full_q;
  assign fmt_data  = buf_q;
  assign drq       = is_wr ? !full_q : full_q;
  assign rd_data   = (dack && !dack_wr) ? buf_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      buf_q  <= '0;
    end else if (dir_chg) begin
      full_q <= 1'b0;
    end else if (!is_wr) begin
      if (dack) begin
        full_q <= 1'b0;
      end else if (sep_valid && sep_ready) begin
        full_q <= 1'b1;
        buf_q  <= sep_data;
      end
    end else begin
      if (full_q && fmt_ready) begin
        full_q <= 1'b0;
      end else if (!full_q && dack && dack_wr) begin
        full_q <= 1'b1;
        buf_q  <= wdata_q;
      end
    end
  end
endmodule

// File: rtl/dma_ready_trap.sv
module dma_ready_trap
  import dma_trap_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter int                CTL_W      = 16,
  parameter int                ARM_BIT    = 14,
  parameter int                ACK_BIT    = 4,
  parameter int                TMO_BIT    = 6,
  parameter int                DIR_BIT    = 0,
  parameter int                TMO_CYCLES = 3000,
  parameter logic [ADDR_W-1:0] WAIT_ADDR  = 16'hFE00,
  parameter logic [ADDR_W-1:0] RD_ADDR    = 16'hFE02,
  parameter logic [ADDR_W-1:0] WR_ADDR    = 16'hFE04,
  localparam int               IDX_W      = $clog2(CTL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_ready,
  input  logic              ctl_we,
  input  logic [IDX_W-1:0]  ctl_idx,
  input  logic              ctl_val,
  output logic              tmo_active,
  output logic              dack_n,
  output logic              drq,
  input  logic              sep_valid,
  input  logic [DATA_W-1:0] sep_data,
  output logic              sep_ready,
  output logic              fmt_valid,
  output logic [DATA_W-1:0] fmt_data,
  input  logic              fmt_ready
);
  logic              arm_w;
  logic              ack_w;
  xfer_dir_e         dir_w;
  logic              dir_chg_w;
  logic              wait_hit_w;
  logic              dack_w;
  logic              dack_wr_w;
  logic [DATA_W-1:0] wdata_w;

  trap_ctl_port #(
    .CTL_W(CTL_W), .ARM_BIT(ARM_BIT), .ACK_BIT(ACK_BIT),
    .DIR_BIT(DIR_BIT), .TMO_BIT(TMO_BIT), .TMO_CYCLES(TMO_CYCLES)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_idx(ctl_idx),
    .ctl_val(ctl_val), .arm(arm_w), .ack(ack_w), .dir(dir_w),
    .dir_chg(dir_chg_w), .tmo_active(tmo_active)
  );

  trap_addr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_ADDR(WAIT_ADDR),
    .RD_ADDR(RD_ADDR), .WR_ADDR(WR_ADDR)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .ack(ack_w),
    .wait_hit(wait_hit_w), .dack(dack_w), .dack_wr(dack_wr_w),
    .wdata_q(wdata_w)
  );

  trap_ready_gate u_gate (
    .clk(clk), .rst_n(rst_n), .arm(arm_w), .tmo_active(tmo_active),
    .drq(drq), .wait_hit(wait_hit_w), .cpu_ready(cpu_ready)
  );

  trap_drq_model #(.DATA_W(DATA_W)) u_drq (
    .clk(clk), .rst_n(rst_n), .dir(dir_w), .dir_chg(dir_chg_w),
    .dack(dack_w), .dack_wr(dack_wr_w), .wdata_q(wdata_w),
    .sep_valid(sep_valid), .sep_data(sep_data), .sep_ready(sep_ready),
    .fmt_valid(fmt_valid), .fmt_data(fmt_data), .fmt_ready(fmt_ready),
    .drq(drq), .rd_data(bus_rdata)
  );

  assign dack_n = !dack_w;
endmodule

// File: rtl/dma_ready_trap_chk.sv
module dma_ready_trap_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              ack,
  input logic              dir,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              cpu_ready,
  input logic              tmo_active,
  input logic              drq,
  input logic              dack_n,
  input logic              sep_ready,
  input logic              fmt_valid,
  input logic              fmt_ready,
  input logic [DATA_W-1:0] fmt_data
);
  AST_DISARMED_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |-> cpu_ready); // R2

  AST_DRQ_READY: assert property (@(posedge clk) disable iff (!rst_n)
    drq |-> cpu_ready); // R3

  AST_IDLE_TIMER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_active |-> cpu_ready); // R4

  AST_DISARM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arm) |-> cpu_ready); // R5

  AST_DACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !bus_wr && !ack) |=> dack_n); // R6

  AST_DACK_CLEARS_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!dack_n && !dir) |=> (!drq || dir)); // R7

  AST_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_valid && !fmt_ready) |=> ((fmt_valid && $stable(fmt_data)) || !dir)); // R9

  AST_SEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    sep_ready |-> (!drq && dack_n && !dir)); // R10
endmodule

bind dma_ready_trap dma_ready_trap_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm_w), .ack(ack_w), .dir(dir_w),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .cpu_ready(cpu_ready),
  .tmo_active(tmo_active), .drq(drq), .dack_n(dack_n),
  .sep_ready(sep_ready), .fmt_valid(fmt_valid), .fmt_ready(fmt_ready),
  .fmt_data(fmt_data)
);

// File: tb/dma_ready_trap_tb.sv
`timescale 1ns/1ps
module dma_ready_trap_tb;
  localparam int          TMO    = 3000;
  localparam logic [15:0] A_WAIT = 16'hFE00;
  localparam logic [15:0] A_RD   = 16'hFE02;
  localparam logic [15:0] A_WR   = 16'hFE04;
  localparam logic [3:0]  B_ARM  = 4'd14;
  localparam logic [3:0]  B_ACK  = 4'd4;
  localparam logic [3:0]  B_TMO  = 4'd6;
  localparam logic [3:0]  B_DIR  = 4'd0;

  typedef struct packed {
    logic        arm;
    logic        tmr;
    logic [15:0] addr;
    logic        rd;
    logic        wr;
    logic        exp_rdy;
    logic        exp_dack_n;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 16'hFE00, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 read at wait
    '{1'b1, 1'b1, 16'hFE00, 1'b0, 1'b1, 1'b0, 1'b1}, // R3 write at wait
    '{1'b0, 1'b1, 16'hFE00, 1'b1, 1'b0, 1'b1, 1'b1}, // R2 disarmed
    '{1'b1, 1'b0, 16'hFE00, 1'b1, 1'b0, 1'b1, 1'b1}, // R4 timer idle
    '{1'b1, 1'b1, 16'hFE02, 1'b1, 1'b0, 1'b1, 1'b0}, // R6 read ack
    '{1'b1, 1'b1, 16'hFE04, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 write ack
    '{1'b1, 1'b1, 16'hFE01, 1'b1, 1'b0, 1'b1, 1'b1}, // R12 near miss
    '{1'b0, 1'b0, 16'hFE02, 1'b1, 1'b0, 1'b1, 1'b0}, // R6 ack needs no arm
    '{1'b1, 1'b1, 16'hFE00, 1'b0, 1'b0, 1'b1, 1'b1}, // R12 no strobe
    '{1'b1, 1'b1, 16'hFE02, 1'b0, 1'b1, 1'b1, 1'b1}  // R12 write at read addr
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        cpu_ready;
  logic        ctl_we = 1'b0;
  logic [3:0]  ctl_idx = '0;
  logic        ctl_val = 1'b0;
  logic        tmo_active;
  logic        dack_n;
  logic        drq;
  logic        sep_valid = 1'b0;
  logic [7:0]  sep_data = '0;
  logic        sep_ready;
  logic        fmt_valid;
  logic [7:0]  fmt_data;
  logic        fmt_ready = 1'b0;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dma_ready_trap #(.TMO_CYCLES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_ready(cpu_ready), .ctl_we(ctl_we), .ctl_idx(ctl_idx),
    .ctl_val(ctl_val), .tmo_active(tmo_active), .dack_n(dack_n),
    .drq(drq), .sep_valid(sep_valid), .sep_data(sep_data),
    .sep_ready(sep_ready), .fmt_valid(fmt_valid), .fmt_data(fmt_data),
    .fmt_ready(fmt_ready)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp,
                       input string req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl_set(input logic [3:0] idx, input logic val);
    ctl_we  = 1'b1;
    ctl_idx = idx;
    ctl_val = val;
    tick();
    ctl_we  = 1'b0;
  endtask

  task automatic bus_idle();
    bus_rd = 1'b0;
    bus_wr = 1'b0;
    bus_addr = '0;
  endtask

  task automatic load_sep(input logic [7:0] b);
    sep_valid = 1'b1;
    sep_data  = b;
    tick();
    sep_valid = 1'b0;
  endtask

  task automatic wait_timer_idle();
    for (int k = 0; k < TMO + 4 && tmo_active; k++) tick();
  endtask

  initial begin
    #(100_000 * 4);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int errs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(16'(cpu_ready), 16'd1, "R1", "ready");
    check(16'(dack_n), 16'd1, "R1", "dack_n");
    check(16'(drq), 16'd0, "R1", "drq");
    check(16'(tmo_active), 16'd0, "R1", "tmo_active");
    check(16'(sep_ready), 16'd1, "R1", "sep_ready");
    check(16'(fmt_valid), 16'd0, "R1", "fmt_valid");
    @(negedge clk);

    // decode table: R2 R3 R4 R6 R12
    for (int i = 0; i < NV; i++) begin
      ctl_set(B_ARM, VECS[i].arm);
      if (VECS[i].tmr) ctl_set(B_TMO, 1'b1);
      else wait_timer_idle();
      bus_addr = VECS[i].addr;
      bus_rd   = VECS[i].rd;
      bus_wr   = VECS[i].wr;
      #1;
      check(16'(cpu_ready), 16'(VECS[i].exp_rdy), "R3 R2 R4 R12 table", $sformatf("ready v%0d", i));
      tick();
      check(16'(dack_n), 16'(VECS[i].exp_dack_n), "R6 R12 table", $sformatf("dack_n v%0d", i));
      bus_idle();
      ctl_set(B_ARM, 1'b0);
      check(16'(cpu_ready), 16'd1, "R5 table", $sformatf("ready after v%0d", i));
      check(16'(dack_n), 16'd1, "R6 table", $sformatf("dack release v%0d", i));
    end

    // R3: stall released when DRQ rises, then R6/R7 read acknowledge
    ctl_set(B_ARM, 1'b1);
    ctl_set(B_TMO, 1'b1);
    bus_addr = A_WAIT; bus_rd = 1'b1;
    repeat (3) tick();
    check(16'(cpu_ready), 16'd0, "R3", "held low without drq");
    load_sep(8'hA5);
    check(16'(drq), 16'd1, "R10", "drq after byte");
    check(16'(cpu_ready), 16'd1, "R3", "ready on drq");
    check(16'(sep_ready), 16'd0, "R10", "sep_ready while full");
    bus_idle();
    bus_addr = A_RD; bus_rd = 1'b1;
    tick();
    check(16'(dack_n), 16'd0, "R6", "read ack");
    check(16'(bus_rdata), 16'hA5, "R6", "read data");
    bus_idle();
    tick();
    check(16'(drq), 16'd0, "R7", "drq cleared by ack");
    check(16'(dack_n), 16'd1, "R6", "ack released");
    ctl_set(B_ARM, 1'b0);

    // R10: separator byte presented while the acknowledge is active
    load_sep(8'h11);
    bus_addr = A_RD; bus_rd = 1'b1;
    tick();
    bus_idle();
    sep_valid = 1'b1; sep_data = 8'h22;
    #1;
    check(16'(sep_ready), 16'd0, "R10", "sep_ready during ack");
    tick();
    check(16'(drq), 16'd0, "R10", "byte not taken during ack");
    check(16'(sep_ready), 16'd1, "R10", "sep_ready after ack");
    tick();
    sep_valid = 1'b0;
    check(16'(drq), 16'd1, "R10", "byte taken after ack");
    bus_addr = A_RD; bus_rd = 1'b1;
    tick();
    check(16'(bus_rdata), 16'h22, "R10", "second byte intact");
    bus_idle();
    tick();

    // R5: disarm releases stall
    ctl_set(B_ARM, 1'b1);
    ctl_set(B_TMO, 1'b1);
    bus_addr = A_WAIT; bus_rd = 1'b1;
    tick();
    check(16'(cpu_ready), 16'd0, "R5", "stalled before disarm");
    ctl_set(B_ARM, 1'b0);
    check(16'(cpu_ready), 16'd1, "R5", "released by disarm");
    bus_idle();

    // R8: stale byte discarded through the control acknowledge bit
    load_sep(8'h77);
    check(16'(drq), 16'd1, "R8", "stale drq present");
    ctl_set(B_ACK, 1'b1);
    tick();
    tick();
    check(16'(dack_n), 16'd0, "R8", "ack bit drives dack_n");
    check(16'(drq), 16'd0, "R8", "stale drq dropped");
    check(16'(fmt_valid), 16'd0, "R8", "nothing emitted");
    ctl_set(B_ACK, 1'b0);
    tick();
    check(16'(dack_n), 16'd1, "R8", "ack bit cleared");

    // R9: write direction with formatter back-pressure
    ctl_set(B_DIR, 1'b1);
    check(16'(drq), 16'd1, "R9", "empty buffer requests");
    check(16'(sep_ready), 16'd0, "R9", "separator closed in write mode");
    bus_addr = A_WR; bus_wr = 1'b1; bus_wdata = 8'h3C;
    tick();
    bus_idle();
    check(16'(dack_n), 16'd0, "R9", "write ack");
    tick();
    check(16'(drq), 16'd0, "R9", "drq falls after load");
    check(16'(fmt_valid), 16'd1, "R9", "byte offered");
    check(16'(fmt_data), 16'h3C, "R9", "byte value");
    tick();
    tick();
    check(16'(fmt_valid), 16'd1, "R9", "held under back-pressure");
    check(16'(fmt_data), 16'h3C, "R9", "value held");
    fmt_ready = 1'b1;
    tick();
    fmt_ready = 1'b0;
    check(16'(fmt_valid), 16'd0, "R9", "accepted");
    check(16'(drq), 16'd1, "R9", "request again");
    ctl_set(B_DIR, 1'b0);
    check(16'(drq), 16'd0, "R9", "back to read mode");

    // R4/R11: timeout breaks a stall after exactly TMO cycles
    wait_timer_idle();
    ctl_set(B_ARM, 1'b1);
    ctl_set(B_TMO, 1'b1);
    bus_addr = A_WAIT; bus_rd = 1'b1;
    repeat (TMO - 1) tick();
    check(16'(tmo_active), 16'd1, "R11", "timer in last cycle");
    check(16'(cpu_ready), 16'd0, "R4", "still stalled");
    tick();
    check(16'(tmo_active), 16'd0, "R11", "timer expired");
    check(16'(cpu_ready), 16'd1, "R4", "released by timeout");
    bus_idle();
    ctl_set(B_ARM, 1'b0);

    // R4: stall raised in the timer's final running cycle
    ctl_set(B_ARM, 1'b1);
    ctl_set(B_TMO, 1'b1);
    repeat (TMO - 1) tick();
    bus_addr = A_WAIT; bus_rd = 1'b1;
    #1;
    check(16'(cpu_ready), 16'd0, "R4", "stall in last timer cycle");
    tick();
    check(16'(cpu_ready), 16'd1, "R4", "released at expiry edge");
    bus_idle();
    ctl_set(B_ARM, 1'b0);

    // R3: full 256-byte sector loop completes before timeout
    errs = 0;
    ctl_set(B_ARM, 1'b1);
    ctl_set(B_TMO, 1'b1);
    for (int n = 0; n < 256; n++) begin
      bus_addr = A_WAIT; bus_rd = 1'b1;
      tick();
      if (cpu_ready !== 1'b0) errs++;
      load_sep(8'(n) ^ 8'h5A);
      if (cpu_ready !== 1'b1) errs++;
      bus_idle();
      bus_addr = A_RD; bus_rd = 1'b1;
      tick();
      got = bus_rdata;
      if (got !== (8'(n) ^ 8'h5A)) errs++;
      bus_idle();
      tick();
    end
    check(16'(errs), 16'd0, "R3", "sector loop errors");
    check(16'(tmo_active), 16'd1, "R11", "sector done before timeout");
    ctl_set(B_ARM, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule